// File: doc/BRIEF.md
# Subcode-Q Capture Buffer with Nibble Readout

This block sits between a CD decoder and a host CPU. The decoder sends the subcode-Q channel as a serial bit stream, one bit per frame clock period, with a pair of sync flags that mark the start of each block. The block captures the 80 payload bits of each 96-bit block into one of two 20-nibble banks. It ignores the 16 check bits. Each new block goes into the other bank.

The decoder reports a separate CRC verdict for a block while the next block is arriving. The block samples that verdict at the sync that closes the earlier block. If the verdict is good, the bank is offered to the host: the read-enable flag drops, the first nibble is preloaded, and one clock later the data/command line drops. Until the host issues a read command, the host sees read-enable mirrored on bus line 2. After the read command, the bus carries nibble 0, and each read strobe moves on to the next nibble. The offer is withdrawn after the twentieth strobe, or when a sync begins writing into that same bank.

All inputs are synchronous to `clk_i`. The frame clock is oversampled, and its falling edge is detected in the `clk_i` domain.

Top module: `subq_reader`

## Requirements
- R1: A frame clock falling edge at which `s0_i` and `s1_i` are both high is a sync. It clears the bit count and switches the write bank. The sync edge carries no payload bit. A falling edge with only one of the two flags high is an ordinary data edge.
- R2: Data is sampled on frame clock falling edges. Payload bit k of a block (k = 0 first after the sync) is stored in word k/4 at bit position 3 - (k mod 4), so the first bit of each nibble appears on `bus_o[3]`.
- R3: Only bits 0 to 79 are stored. Bits 80 to 95 are counted and dropped. Bits after the 96th do not change the stored payload or the count.
- R4: At a sync, the block that just ended is released when it received at least 96 bits and `crc_ok_i` is high at that edge. `rd_en_no` then reads low two clocks after the falling edge is applied. A block cut short by the sync, and the interval before the first sync, are never released.
- R5: A low `crc_ok_i` at the closing sync leaves that block unreleased.
- R6: After reset, `rd_en_no` and `dc_no` are high. On release, `dc_no` falls exactly one clock after `rd_en_no`, with nibble 0 already preloaded.
- R7: Outside a read, `bus_o` is zero except `bus_o[2]`, which mirrors `rd_en_no`.
- R8: `rd_cmd_i` while `dc_no` is low starts a read, and `bus_o` shows nibble 0. Each `rd_strb_i` shows the next nibble. The 20th strobe ends the read and raises `rd_en_no` and `dc_no`. `rd_cmd_i` with `dc_no` high is ignored, and `rd_strb_i` outside a read is ignored.
- R9: A sync that starts writing into the released bank withdraws the offer and aborts any read, unless the same sync releases the other bank.
- R10: A released block stays intact while the following block is being written into the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fck_i | input | 1 | Frame clock; falling edges sample data and sync |
| s0_i | input | 1 | Sync flag 0 |
| s1_i | input | 1 | Sync flag 1 |
| subq_i | input | 1 | Serial subcode-Q bit |
| crc_ok_i | input | 1 | CRC verdict for the previous block, sampled at sync |
| rd_cmd_i | input | 1 | Host read command, one-clock pulse |
| rd_strb_i | input | 1 | Host read strobe, advances the nibble |
| rd_en_no | output | 1 | Read enable, active low |
| dc_no | output | 1 | Data ready line, active low |
| bus_o | output | 4 | Nibble data during a read, otherwise monitor word |

## Verification
A wrong bit count or a wrong bank select does not stay hidden. It shows up as a release decision, high or low on `rd_en_no`, within two clocks of the next sync falling edge. It also shows up as a nibble mismatch on `bus_o` during the next readout. A slip in the read address or the preload shows on the first command or strobe that follows it. A missed withdrawal leaves `rd_en_no` low after a sync, and the bench checks `rd_en_no` after every sync. Random blocks, random verdicts and random partial reads are mixed with directed short, long, overwrite and mid-capture reads.

// File: rtl/subq_pkg.sv
package subq_pkg;
  parameter int NIB_W      = 4;
  parameter int DATA_BITS  = 80;
  parameter int FRAME_BITS = 96;
  parameter int MON_BIT    = 2;
  localparam int NWORDS    = DATA_BITS / NIB_W;
  localparam int CNT_W     = $clog2(FRAME_BITS + 1);
  localparam int ADDR_W    = $clog2(NWORDS + 1);
  localparam int BPOS_W    = $clog2(NIB_W);
endpackage

// File: rtl/subq_rx.sv
module subq_rx
  import subq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fck_i,
  input  logic              s0_i,
  input  logic              s1_i,
  input  logic              subq_i,
  output logic              sync_o,
  output logic              wr_bank_o,
  output logic              full_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [BPOS_W-1:0] wbit_o,
  output logic              wdata_o
);
  logic             fck_q, armed_q, bank_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall      = fck_q & ~fck_i;
  assign sync_o    = fall & s0_i & s1_i;
  assign wr_bank_o = bank_q;
  assign full_o    = armed_q && (cnt_q == CNT_W'(FRAME_BITS));
  assign we_o      = fall && !sync_o && armed_q && (cnt_q < CNT_W'(DATA_BITS));
  assign waddr_o   = ADDR_W'(cnt_q >> BPOS_W);
  // MSB-first inside each nibble
  assign wbit_o    = BPOS_W'(NIB_W - 1) - cnt_q[BPOS_W-1:0];
  assign wdata_o   = subq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fck_q   <= 1'b1;
      armed_q <= 1'b0;
      bank_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      fck_q <= fck_i;
      if (sync_o) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        bank_q  <= ~bank_q;
      end else if (fall && armed_q && cnt_q < CNT_W'(FRAME_BITS)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));
  p_sync_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> (cnt_q == '0) && (bank_q != $past(bank_q)));
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(cnt_q));
endmodule

// File: rtl/subq_ram.sv
module subq_ram
  import subq_pkg::*;
(
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wbank_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BPOS_W-1:0] wbit_i,
  input  logic              wdata_i,
  input  logic              rbank_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [NIB_W-1:0]  rdata_o
);
  logic [NIB_W-1:0] mem_q [2][NWORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbank_i][waddr_i][wbit_i] <= wdata_i;
  end

  assign rdata_o = (raddr_i < ADDR_W'(NWORDS)) ? mem_q[rbank_i][raddr_i] : '0;
endmodule

// File: rtl/subq_host.sv
module subq_host
  import subq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              wr_bank_i,
  input  logic              full_i,
  input  logic              crc_ok_i,
  input  logic              rd_cmd_i,
  input  logic              rd_strb_i,
  input  logic [NIB_W-1:0]  rdata_i,
  output logic              rbank_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              rd_en_no,
  output logic              dc_no,
  output logic [NIB_W-1:0]  bus_o
);
  logic              en_n_q, dc_n_q, bank_q, pend_q, reading_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  nib_q, mon;

  assign rbank_o  = bank_q;
  assign raddr_o  = pend_q ? addr_q : ADDR_W'(addr_q + 1'b1);
  assign rd_en_no = en_n_q;
  assign dc_no    = dc_n_q;

  always_comb begin
    mon          = '0;
    mon[MON_BIT] = en_n_q;
    bus_o        = reading_q ? nib_q : mon;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_n_q    <= 1'b1;
      dc_n_q    <= 1'b1;
      bank_q    <= 1'b0;
      pend_q    <= 1'b0;
      reading_q <= 1'b0;
      addr_q    <= '0;
      nib_q     <= '0;
    end else if (sync_i) begin
      if (full_i && crc_ok_i) begin
        en_n_q    <= 1'b0;
        dc_n_q    <= 1'b1;
        bank_q    <= wr_bank_i;  // bank just closed
        addr_q    <= '0;
        pend_q    <= 1'b1;
        reading_q <= 1'b0;
      end else if (!en_n_q && bank_q == ~wr_bank_i) begin
        en_n_q    <= 1'b1;
        dc_n_q    <= 1'b1;
        pend_q    <= 1'b0;
        reading_q <= 1'b0;
      end
    end else if (pend_q) begin
      nib_q  <= rdata_i;
      dc_n_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (reading_q && rd_strb_i) begin
      if (addr_q == ADDR_W'(NWORDS - 1)) begin
        en_n_q    <= 1'b1;
        dc_n_q    <= 1'b1;
        reading_q <= 1'b0;
      end else begin
        addr_q <= raddr_o;
        nib_q  <= rdata_i;
      end
    end else if (rd_cmd_i && !dc_n_q && !reading_q) begin
      reading_q <= 1'b1;
    end
  end

  p_dc_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dc_n_q |-> !en_n_q);
  p_dc_lags_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_n_q) |=> $fell(dc_n_q));
  p_read_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reading_q |-> (!en_n_q && !dc_n_q));
  p_addr_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q < ADDR_W'(NWORDS));
  p_monitor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reading_q |-> (bus_o[MON_BIT] == rd_en_no && $countones(bus_o) <= 1));
endmodule

// File: rtl/subq_reader.sv
module subq_reader
  import subq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fck_i,
  input  logic             s0_i,
  input  logic             s1_i,
  input  logic             subq_i,
  input  logic             crc_ok_i,
  input  logic             rd_cmd_i,
  input  logic             rd_strb_i,
  output logic             rd_en_no,
  output logic             dc_no,
  output logic [NIB_W-1:0] bus_o
);
  logic              sync, wr_bank, full, we, wdata, rbank;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [BPOS_W-1:0] wbit;
  logic [NIB_W-1:0]  rdata;

  subq_rx u_rx (
    .clk_i, .rst_ni, .fck_i, .s0_i, .s1_i, .subq_i,
    .sync_o(sync), .wr_bank_o(wr_bank), .full_o(full), .we_o(we),
    .waddr_o(waddr), .wbit_o(wbit), .wdata_o(wdata)
  );

  subq_ram u_ram (
    .clk_i, .we_i(we), .wbank_i(wr_bank), .waddr_i(waddr), .wbit_i(wbit),
    .wdata_i(wdata), .rbank_i(rbank), .raddr_i(raddr), .rdata_o(rdata)
  );

  subq_host u_host (
    .clk_i, .rst_ni, .sync_i(sync), .wr_bank_i(wr_bank), .full_i(full),
    .crc_ok_i, .rd_cmd_i, .rd_strb_i, .rdata_i(rdata), .rbank_o(rbank),
    .raddr_o(raddr), .rd_en_no, .dc_no, .bus_o
  );

  // R10: released bank is never the write target while offered
  p_no_write_offered_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && !rd_en_no) |-> (wr_bank != rbank));
endmodule

// File: tb/sim_subq_reader.sv
module sim_subq_reader;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fck = 1'b1, s0 = 1'b0, s1 = 1'b0, dbit = 1'b0, crc = 1'b0;
  logic cmd = 1'b0, strb = 1'b0;
  logic rd_en_n, dc_n;
  logic [3:0] bus;

  int vec = 0, bad = 0;
  bit done = 0;

  logic [3:0] cur [20];
  logic [3:0] rel [20];
  int  cnt_m = 0;
  bit  armed_m = 0, rel_v = 0;

  always #(TCLK/2) clk = ~clk;

  subq_reader u0 (
    .clk_i(clk), .rst_ni(rst_n), .fck_i(fck), .s0_i(s0), .s1_i(s1),
    .subq_i(dbit), .crc_ok_i(crc), .rd_cmd_i(cmd), .rd_strb_i(strb),
    .rd_en_no(rd_en_n), .dc_no(dc_n), .bus_o(bus)
  );

  function automatic logic [3:0] mon_word(input logic en_n);
    return {1'b0, en_n, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_bit(input logic a, input logic b, input logic d, input logic c);
    @(negedge clk);
    s0 = a; s1 = b; dbit = d; crc = c; fck = 1'b1;
    repeat (2) @(negedge clk);
    fck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_sync(input logic c);
    edge_bit(1'b1, 1'b1, 1'($urandom % 2), c);
    rel_v = armed_m && cnt_m >= 96 && c;
    if (rel_v) for (int i = 0; i < 20; i++) rel[i] = cur[i];
    armed_m = 1; cnt_m = 0;
    chk("R4/R5/R9 rd_en after sync", {3'b0, rd_en_n}, {3'b0, !rel_v});
    chk("R6 dc after sync", {3'b0, dc_n}, {3'b0, !rel_v});
    chk("R7 monitor after sync", bus, mon_word(!rel_v));
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = $urandom;
      // never both flags high: R1 single-flag edge is data
      edge_bit(r[0], ~r[0] & r[1], r[2], r[3]);
      if (armed_m && cnt_m < 80) cur[cnt_m/4][3 - cnt_m%4] = r[2];
      if (armed_m && cnt_m < 96) cnt_m++;
    end
  endtask

  task automatic pulse(input bit is_cmd);
    @(negedge clk);
    if (is_cmd) cmd = 1'b1; else strb = 1'b1;
    @(negedge clk);
    cmd = 1'b0; strb = 1'b0;
  endtask

  task automatic read_block(input int nstrb);
    pulse(1);
    chk("R8 nibble 0 after command", bus, rel[0]);
    for (int i = 1; i <= nstrb && i < 20; i++) begin
      pulse(0);
      chk("R2 nibble readout", bus, rel[i]);
    end
    if (nstrb >= 20) begin
      pulse(0);
      rel_v = 0;
      chk("R8 rd_en high after 20th strobe", {3'b0, rd_en_n}, 4'd1);
      chk("R8 dc high after 20th strobe", {3'b0, dc_n}, 4'd1);
      chk("R7 monitor after read", bus, mon_word(1'b1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 20; i++) begin cur[i] = '0; rel[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset rd_en", {3'b0, rd_en_n}, 4'd1);
    chk("R6 reset dc", {3'b0, dc_n}, 4'd1);
    chk("R7 reset monitor", bus, mon_word(1'b1));

    // R4: bits before first sync and first sync release nothing
    send_bits(100);
    send_sync(1'b1);
    // R5: good length, bad verdict
    send_bits(96);
    send_sync(1'b0);
    // release, then ignored host actions
    send_bits(96);
    send_sync(1'b1);
    pulse(0);
    chk("R8 strobe outside read ignored", bus, mon_word(1'b0));
    read_block(20);
    pulse(1);
    chk("R8 command with dc high ignored", bus, mon_word(1'b1));

    // R3: extra bits after 96 ignored
    send_bits(110);
    send_sync(1'b1);
    read_block(20);

    // R4: short block not released
    send_bits(50);
    send_sync(1'b1);

    // R10: read while next block is being captured
    send_bits(96);
    send_sync(1'b1);
    send_bits(40);
    read_block(20);
    send_bits(56);
    send_sync(1'b1);

    // R9: unread bank overwritten by next capture with bad verdict
    pulse(1);
    send_bits(96);
    send_sync(1'b0);
    chk("R9 read aborted bus monitor", bus, mon_word(1'b1));

    for (int k = 0; k < 30; k++) begin
      int nb;
      nb = ($urandom % 8 == 0) ? 60 + $urandom % 30 : 96 + $urandom % 4;
      send_bits(nb);
      send_sync(($urandom % 4) != 0);
      if (rel_v) begin
        if ($urandom % 3 == 0) read_block($urandom % 20);
        else read_block(20);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule